// File: doc/BRIEF.md
# Fifteen-Bit Arithmetic Logic Unit

This block is the execute stage of a small virtual processor with 16-bit words. It receives an operation code and two operand values that the decode stage has already resolved (each normally below 32768). It returns a 16-bit result whose value lives in the low 15 bits. All arithmetic wraps at 2^15. The block covers equality and greater-than compares, addition, multiplication, remainder, bitwise AND and OR, and a 15-bit complement.

A single `start` pulse launches an operation. All operations except remainder finish one cycle later. Remainder runs through an internal restoring shift-subtract divider over 15 iterations. `busy` is high while that divider is in use, and any `start` seen during that time is ignored. `done` pulses for one cycle when the result is ready. The result and the error flag then hold until the next accepted `start`. A remainder by zero does not start the divider: it finishes at once with `div_err` set and a result of 0.

Top module: `alu15`

## Requirements
- R1: Operation codes: 0 equal, 1 greater-than, 2 add, 3 multiply, 4 remainder, 5 AND, 6 OR, 7 NOT. Codes 8 to 15 return 0.
- R2: Equal returns 1 when a equals b and 0 otherwise. Greater-than returns 1 when a is greater than b (unsigned) and 0 otherwise.
- R3: Add returns (a + b) mod 32768. Multiply returns the low 15 bits of a times b, with bit 15 of the result 0.
- R4: Remainder with a nonzero b returns a mod b.
- R5: NOT returns the complement of a masked to 15 bits, so result bit 15 is 0. AND and OR return a & b and a | b.
- R6: Every operation other than remainder sets `done` and the result in the cycle after the `start` cycle, with `busy` staying low.
- R7: A remainder with nonzero b holds `busy` high and sets `done` 16 cycles later than a single-cycle operation would (15 iterations plus one).
- R8: A remainder with b equal to 0 completes in the cycle after `start` with `div_err` 1 and result 0. Every other accepted operation clears `div_err`.
- R9: A `start` while `busy` is high is ignored: the running result, its timing and the number of `done` pulses are unchanged.
- R10: `done` is a one-cycle pulse. The result and `div_err` hold from `done` until the next accepted `start`.
- R11: After reset, `result`, `done`, `busy` and `div_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation (taken when not busy) |
| op | input | 4 | Operation code, see R1 |
| a | input | 16 | First operand value |
| b | input | 16 | Second operand value |
| result | output | 16 | Result, held until next accepted start |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Remainder divider in progress |
| div_err | output | 1 | Last remainder had a zero divisor |

## Verification
A corrupted partial remainder or iteration counter in the divider shows up at the ports only when `done` fires. It appears as a wrong remainder value or a completion that is early or late against the fixed 16-cycle gap, so every remainder check also measures the latency. A busy flag that drops too early would let an overlapping `start` through. That shows within a cycle as an extra `done` or as the overlapping operation's result replacing the remainder. A hold register that reloads when it should not would change `result` during the idle cycles the bench watches after each completion.

// File: rtl/alu15_pkg.sv
// Package: shared operation codes and widths for the 15-bit ALU.
// Assumes operand values fit in the word width; value width is one less.
package alu15_pkg;
    localparam int WORD_W = 16;
    localparam int VAL_W  = WORD_W - 1;

    typedef enum logic [3:0] {
        OP_EQ  = 4'd0,
        OP_GT  = 4'd1,
        OP_ADD = 4'd2,
        OP_MUL = 4'd3,
        OP_MOD = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_NOT = 4'd7
    } alu_op_e;
endpackage

// File: rtl/alu15_onecycle.sv
// Module: combinational datapath for every operation except remainder.
// Assumes the caller registers the output; unknown codes give zero.
module alu15_onecycle #(
    parameter int WW = 16,
    localparam int VW = WW - 1
) (
    input  logic [3:0]    op,
    input  logic [WW-1:0] a,
    input  logic [WW-1:0] b,
    output logic [WW-1:0] y
);
    import alu15_pkg::*;

    logic [2*VW-1:0] prod;
    logic [WW:0]     sum;

    // full-width intermediates for the wrapping operations
    always_comb begin
        prod = a[VW-1:0] * b[VW-1:0];
        sum  = {1'b0, a} + {1'b0, b};
    end

    // select the result for the requested operation
    always_comb begin
        y = '0;
        case (op)
            OP_EQ:   y = {{(WW-1){1'b0}}, a == b};
            OP_GT:   y = {{(WW-1){1'b0}}, a > b};
            OP_ADD:  y = {1'b0, sum[VW-1:0]};
            OP_MUL:  y = {1'b0, prod[VW-1:0]};
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOT:  y = {1'b0, ~a[VW-1:0]};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu15_divider.sv
// Module: restoring shift-subtract remainder unit, one bit per cycle.
// Assumes divisor is nonzero when load is pulsed; fin pulses after the
// last of VW iterations with rem holding the final remainder.
module alu15_divider #(
    parameter int VW = 15,
    localparam int CW = $clog2(VW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [VW-1:0] rem,
    output logic          fin
);
    logic [VW-1:0] shq;
    logic [VW-1:0] dvs;
    logic [CW-1:0] cnt;
    logic          run;
    logic [VW:0]   trial;

    // next partial remainder candidate before the subtract decision
    always_comb trial = {rem, shq[VW-1]};

    // iteration state: load operands, then shift and subtract each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shq <= '0;
            dvs <= '0;
            rem <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                shq <= dividend;
                dvs <= divisor;
                rem <= '0;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                shq <= shq << 1;
                if (trial >= {1'b0, dvs})
                    rem <= VW'(trial - {1'b0, dvs});
                else
                    rem <= trial[VW-1:0];
                if (cnt == CW'(VW - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem < dvs)); // R4
    AST_FIN_ONLY_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> $past(run)); // R7
endmodule

// File: rtl/alu15.sv
// Module: top of the 15-bit ALU with a start/done handshake.
// Assumes operand values are below 2**VAL_W; a start while busy is dropped.
module alu15 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [3:0]  op,
    input  logic [15:0] a,
    input  logic [15:0] b,
    output logic [15:0] result,
    output logic        done,
    output logic        busy,
    output logic        div_err
);
    import alu15_pkg::*;

    localparam int WW = WORD_W;
    localparam int VW = VAL_W;

    logic [WW-1:0] y_fast;
    logic [VW-1:0] div_rem;
    logic          div_fin;
    logic          accept;
    logic          is_mod;
    logic          zero_div;
    logic          div_load;
    logic [3:0]    op_q;

    // request decode
    always_comb begin
        accept   = start && !busy;
        is_mod   = (op == OP_MOD);
        zero_div = (b == '0);
        div_load = accept && is_mod && !zero_div;
    end

    alu15_onecycle #(.WW(WW)) u_fast (
        .op (op),
        .a  (a),
        .b  (b),
        .y  (y_fast)
    );

    alu15_divider #(.VW(VW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (a[VW-1:0]),
        .divisor  (b[VW-1:0]),
        .rem      (div_rem),
        .fin      (div_fin)
    );

    // result, handshake and error state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            done    <= 1'b0;
            busy    <= 1'b0;
            div_err <= 1'b0;
            op_q    <= '0;
        end else if (accept) begin
            op_q    <= op;
            div_err <= 1'b0;
            if (is_mod && zero_div) begin
                result  <= '0;
                done    <= 1'b1;
                div_err <= 1'b1;
            end else if (is_mod) begin
                busy <= 1'b1;
                done <= 1'b0;
            end else begin
                result <= y_fast;
                done   <= 1'b1;
            end
        end else if (div_fin) begin
            result <= {1'b0, div_rem};
            done   <= 1'b1;
            busy   <= 1'b0;
        end else begin
            done <= 1'b0;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && $stable(div_err) && !done)); // R10
    AST_NOT_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_NOT) |-> (result[WW-1] == 1'b0)); // R5
    AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_EQ || op_q == OP_GT)) |-> (result <= 16'd1)); // R2
    AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (result == '0 && op_q == OP_MOD)); // R8
    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R7
    AST_BUSY_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (op_q == $past(op_q))); // R9
endmodule

// File: tb/test_alu15.sv
`timescale 1ns/1ps
// Directed bench for alu15: one task per scenario, each checking itself.
module test_alu15;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [15:0] result;
    logic        done;
    logic        busy;
    logic        div_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    alu15 i_alu15 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (op),
        .a       (a),
        .b       (b),
        .result  (result),
        .done    (done),
        .busy    (busy),
        .div_err (div_err)
    );

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // issue one operation and wait for done; returns result and latency
    task automatic issue(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                         output int res, output int lat, output int err);
        @(negedge clk);
        op = o; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        res = result;
        err = div_err;
    endtask

    task automatic t_reset();
        check("R11 result", result, 0);
        check("R11 done", done, 0);
        check("R11 busy", busy, 0);
        check("R11 div_err", div_err, 0);
    endtask

    task automatic t_fast(input string req, input logic [3:0] o, input int x, input int y, input int exp);
        int res, lat, err;
        issue(o, 16'(x), 16'(y), res, lat, err);
        check(req, res, exp);
        check("R6 latency", lat, 0);
        check("R8 err clear", err, 0);
    endtask

    task automatic t_mod(input int x, input int y, input int exp);
        int res, lat, err;
        issue(4'd4, 16'(x), 16'(y), res, lat, err);
        check("R4 remainder", res, exp);
        check("R7 latency", lat, 16);
        check("R8 err clear", err, 0);
    endtask

    task automatic t_div_zero();
        int res, lat, err;
        issue(4'd4, 16'd1234, 16'd0, res, lat, err);
        check("R8 zero result", res, 0);
        check("R8 zero latency", lat, 0);
        check("R8 err set", err, 1);
        check("R8 not busy", busy, 0);
        t_fast("R8 err cleared by add", 4'd2, 1, 2, 3);
    endtask

    task automatic t_busy_ignore();
        int lat;
        int dones;
        @(negedge clk);
        op = 4'd4; a = 16'd1000; b = 16'd37; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy high", busy, 1);
        lat = 0;
        repeat (2) begin @(negedge clk); lat++; end
        op = 4'd2; a = 16'd5; b = 16'd6; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R9 latency", lat, 16);
        check("R9 result", result, 1000 % 37);
        dones = 0;
        repeat (5) begin
            @(negedge clk);
            if (done) dones++;
            check("R10 hold", result, 1000 % 37);
        end
        check("R9 R10 extra done", dones, 0);
    endtask

    task automatic t_hold_err();
        int res, lat, err;
        issue(4'd4, 16'd9, 16'd0, res, lat, err);
        @(negedge clk);
        check("R10 done pulse", done, 0);
        repeat (3) @(negedge clk);
        check("R10 err hold", div_err, 1);
        check("R10 result hold", result, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fast("R2 eq true", 4'd0, 77, 77, 1);
        t_fast("R2 eq false", 4'd0, 77, 78, 0);
        t_fast("R2 gt true", 4'd1, 500, 499, 1);
        t_fast("R2 gt equal", 4'd1, 500, 500, 0);
        t_fast("R3 add", 4'd2, 1000, 2345, 3345);
        t_fast("R3 add wrap", 4'd2, 32767, 1, 0);
        t_fast("R3 mul", 4'd3, 300, 200, 27232);
        t_fast("R3 mul max", 4'd3, 32767, 32767, 1);
        t_fast("R5 and", 4'd5, 16'h5a5a, 16'h0ff0, 16'h0a50);
        t_fast("R5 or", 4'd6, 16'h1200, 16'h0034, 16'h1234);
        t_fast("R5 not", 4'd7, 16'h1234, 0, 16'h6dcb);
        t_fast("R5 not zero", 4'd7, 0, 0, 16'h7fff);
        t_fast("R1 unused code", 4'd9, 100, 3, 0);
        t_fast("R1 unused code 15", 4'd15, 32767, 32767, 0);
        t_mod(100, 7, 2);
        t_mod(32767, 1000, 767);
        t_mod(5, 9, 5);
        t_mod(32767, 1, 0);
        t_mod(32766, 32767, 32766);
        t_div_zero();
        t_busy_ignore();
        t_hold_err();
        finish_run();
    end
endmodule